// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block sits beside the decode and execute stages of a small 16-bit processor. It watches three things. The first is the 24-bit instruction word at fetch. The second is the strobes that write and dereference the sixteen working registers. The third is every reload of the program counter. When it sees an illegal condition, it raises a one-cycle request for a device reset and a two-bit code that names the cause.

The three conditions are:
- an instruction word whose top byte holds the reserved illegal value;
- a working register used as an address pointer before it has ever been written;
- a program-counter reload that lands inside an enabled protected code segment.

A program-counter reload can come from a branch, a call, a return, a computed jump, or an interrupt or trap vector. The block does not tell these apart.

The block keeps a bitmap of which working registers have been written since the last reset. The stack pointer counts as written from reset. The block reports only the first illegal condition it sees. After that it stays silent until the device reset is actually applied through `rst_n`.

Top module: `illc_reset_detect`

## Requirements
- R1: When `fetch_valid` is high and `fetch_word[23:16]` equals 8'h3F, the block requests a reset with cause 2'b01. Any other top byte, or `fetch_valid` low, produces no request.
- R2: While and after `rst_n` is low, `rst_req` is 0 and `cause` is 2'b00. Every working register except register 15 is marked as not written.
- R3: A cycle with `wr_en` high marks register `wr_idx` as written from the next cycle on.
- R4: When `ptr_en` is high and register `ptr_idx` is not marked as written, the block requests a reset with cause 2'b10. Using a register that is marked as written produces no request.
- R5: When a write and a pointer use of the same register fall in the same cycle, the use is judged by the marking as it stood before that write.
- R6: When `reload_en` is high and `reload_target` lies in segment g, the block requests a reset with cause 2'b11. Lying in segment g means `seg_en[g]` is 1 and the target is between `seg_lo[g*16 +: 16]` and `seg_hi[g*16 +: 16]`, both bounds inclusive. A disabled segment never matches.
- R7: `rst_req` rises on the clock edge that samples the condition and stays high for exactly one cycle.
- R8: After the first request, no condition produces a further request until `rst_n` is asserted.
- R9: When conditions coincide, the security cause wins over the uninitialized-register cause, which wins over the illegal-opcode cause.
- R10: `cause` is nonzero whenever `rst_req` is high, and it keeps the reported value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released in step with the clock |
| fetch_valid | input | 1 | `fetch_word` holds a fetched instruction |
| fetch_word | input | 24 | Fetched instruction word |
| wr_en | input | 1 | A working register is written this cycle |
| wr_idx | input | 4 | Index of the register being written |
| ptr_en | input | 1 | A working register is used as an address pointer this cycle |
| ptr_idx | input | 4 | Index of the register used as a pointer |
| reload_en | input | 1 | The program counter is reloaded by a flow change or a vector |
| reload_target | input | 16 | New program-counter value |
| seg_en | input | 2 | Enable for each protected segment |
| seg_lo | input | 32 | Lower bound of each segment, 16 bits per segment |
| seg_hi | input | 32 | Upper bound of each segment, 16 bits per segment |
| rst_req | output | 1 | One-cycle device reset request |
| cause | output | 2 | 01 illegal opcode, 10 uninitialized register, 11 security |

## Verification
The hardest case to reach from the ports is a request that depends on the register bitmap. Some registers must be written and others left unwritten. Every earlier step must stay free of violations, or the first-event latch would hide the result.

The bench reaches this case in three ways:
- It applies a fresh reset before each probe.
- It walks writes through registers 0 to 14 one per cycle, checking at each step that no request appears, before it dereferences them.
- It drives the write and the use of one register in the same cycle.

The bench also sweeps all 256 values of the opcode byte, each after its own reset. It probes both bounds of each protected segment and the addresses just outside them.

// File: rtl/illc_pkg.sv
package illc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_OPCODE   = 2'b01,
    CAUSE_UNINIT   = 2'b10,
    CAUSE_SECURITY = 2'b11
  } cause_e;
endpackage

// File: rtl/illc_reg_tracker.sv
module illc_reg_tracker #(
  parameter int NREGS  = 16,
  parameter int SP_IDX = 15,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_idx,
  output logic             uninit_hit
);
  localparam logic [NREGS-1:0] RST_MAP = NREGS'(1) << SP_IDX;

  logic [NREGS-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d = map_q | (NREGS'(1) << wr_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= RST_MAP;
    else        map_q <= map_d;
  end

  // check uses the map as it stood before any write in this cycle
  assign uninit_hit = use_en && !map_q[use_idx];

  a_r3_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)]);
  a_r2_sp_always_set: assert property (@(posedge clk) disable iff (!rst_n)
    (use_en && use_idx == IDX_W'(SP_IDX)) |-> !uninit_hit);
endmodule

// File: rtl/illc_region_check.sv
module illc_region_check #(
  parameter int ADDR_W = 16,
  parameter int NSEG   = 2
) (
  input  logic                   reload_en,
  input  logic [ADDR_W-1:0]      target,
  input  logic [NSEG-1:0]        seg_en,
  input  logic [NSEG*ADDR_W-1:0] seg_lo,
  input  logic [NSEG*ADDR_W-1:0] seg_hi,
  output logic                   sec_hit
);
  logic [NSEG-1:0] in_seg;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [ADDR_W-1:0] lo, hi;
    assign lo        = seg_lo[g*ADDR_W +: ADDR_W];
    assign hi        = seg_hi[g*ADDR_W +: ADDR_W];
    assign in_seg[g] = seg_en[g] && (target >= lo) && (target <= hi);
  end

  assign sec_hit = reload_en && (|in_seg);
endmodule

// File: rtl/illc_capture.sv
module illc_capture
  import illc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opc_hit,
  input  logic       uninit_hit,
  input  logic       sec_hit,
  output logic       req,
  output logic [1:0] cause
);
  logic   done_q, done_d;
  logic   req_q, req_d;
  cause_e cause_q, cause_d;

  always_comb begin
    done_d  = done_q;
    req_d   = 1'b0;
    cause_d = cause_q;
    if (!done_q && (opc_hit || uninit_hit || sec_hit)) begin
      done_d = 1'b1;
      req_d  = 1'b1;
      if (sec_hit)         cause_d = CAUSE_SECURITY;
      else if (uninit_hit) cause_d = CAUSE_UNINIT;
      else                 cause_d = CAUSE_OPCODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      done_q  <= done_d;
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign req   = req_q;
  assign cause = cause_q;

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  a_r8_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !req_q);
  a_r10_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cause_q != CAUSE_NONE));
  a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !req_q) |-> $stable(cause_q));
  a_r6_security: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_hit && !done_q) |=> (req_q && cause_q == CAUSE_SECURITY));
  a_r9_uninit_over_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (uninit_hit && !sec_hit && !done_q) |=> (cause_q == CAUSE_UNINIT));
endmodule

// File: rtl/illc_reset_detect.sv
module illc_reset_detect #(
  parameter int          ADDR_W     = 16,
  parameter int          NSEG       = 2,
  parameter int          NREGS      = 16,
  parameter int          SP_IDX     = 15,
  parameter logic [7:0]  ILLEGAL_OP = 8'h3F,
  localparam int         IDX_W      = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [23:0]            fetch_word,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   ptr_en,
  input  logic [IDX_W-1:0]       ptr_idx,
  input  logic                   reload_en,
  input  logic [ADDR_W-1:0]      reload_target,
  input  logic [NSEG-1:0]        seg_en,
  input  logic [NSEG*ADDR_W-1:0] seg_lo,
  input  logic [NSEG*ADDR_W-1:0] seg_hi,
  output logic                   rst_req,
  output logic [1:0]             cause
);
  logic opc_hit, uninit_hit, sec_hit;

  assign opc_hit = fetch_valid && (fetch_word[23:16] == ILLEGAL_OP);

  illc_reg_tracker #(.NREGS(NREGS), .SP_IDX(SP_IDX)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .use_en(ptr_en), .use_idx(ptr_idx),
    .uninit_hit(uninit_hit)
  );

  illc_region_check #(.ADDR_W(ADDR_W), .NSEG(NSEG)) u_region (
    .reload_en(reload_en), .target(reload_target),
    .seg_en(seg_en), .seg_lo(seg_lo), .seg_hi(seg_hi),
    .sec_hit(sec_hit)
  );

  illc_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .opc_hit(opc_hit), .uninit_hit(uninit_hit), .sec_hit(sec_hit),
    .req(rst_req), .cause(cause)
  );

  a_r1_opcode_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && cause == 2'b01) |-> $past(fetch_valid && fetch_word[23:16] == ILLEGAL_OP));
endmodule

// File: tb/illc_reset_detect_tb.sv
module illc_reset_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [23:0] fetch_word;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic        ptr_en;
  logic [3:0]  ptr_idx;
  logic        reload_en;
  logic [15:0] reload_target;
  logic [1:0]  seg_en;
  logic [31:0] seg_lo, seg_hi;
  logic        rst_req;
  logic [1:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  illc_reset_detect u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .ptr_en(ptr_en), .ptr_idx(ptr_idx),
    .reload_en(reload_en), .reload_target(reload_target),
    .seg_en(seg_en), .seg_lo(seg_lo), .seg_hi(seg_hi),
    .rst_req(rst_req), .cause(cause)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_word = 24'h0;
    wr_en = 0; wr_idx = 0; ptr_en = 0; ptr_idx = 0;
    reload_en = 0; reload_target = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // inputs are already driven; sample after one edge, then clear and re-check
  task automatic expect_evt(input string tag, input bit exp_req, input int exp_cause);
    @(negedge clk);
    chk({tag, " req"}, int'(rst_req), int'(exp_req));
    if (exp_req) chk({tag, " cause"}, int'(cause), exp_cause);
    idle();
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, int'(rst_req), 0);
  endtask

  task automatic probe_target(input logic [15:0] t, input bit hit);
    do_reset();
    reload_en = 1; reload_target = t;
    expect_evt("R6 target", hit, 3);
  endtask

  initial begin
    seg_en = 2'b11;
    seg_lo = {16'h8000, 16'h0100};
    seg_hi = {16'h80FF, 16'h03FF};
    do_reset();
    chk("R2 reset req", int'(rst_req), 0);
    chk("R2 reset cause", int'(cause), 0);

    // R1: every value of the opcode byte
    for (int b = 0; b < 256; b++) begin
      do_reset();
      fetch_valid = 1; fetch_word = {b[7:0], 16'hA5A5};
      expect_evt("R1 opcode", b == 8'h3F, 1);
    end
    do_reset();
    fetch_valid = 0; fetch_word = 24'h3F0000;
    expect_evt("R1 fetch_valid low", 0, 0);

    // R2/R4: each register straight out of reset
    for (int i = 0; i < 16; i++) begin
      do_reset();
      ptr_en = 1; ptr_idx = i[3:0];
      expect_evt("R4 unwritten use", i != 15, 2);
    end

    // R3: write 0..14 then use each, none may request
    do_reset();
    for (int i = 0; i < 15; i++) begin
      wr_en = 1; wr_idx = i[3:0];
      @(negedge clk);
      chk("R3 write no req", int'(rst_req), 0);
    end
    idle();
    for (int i = 0; i < 16; i++) begin
      ptr_en = 1; ptr_idx = i[3:0];
      @(negedge clk);
      chk("R3 written use", int'(rst_req), 0);
    end
    idle();

    // R5: same-cycle write and use
    do_reset();
    wr_en = 1; wr_idx = 4'd3; ptr_en = 1; ptr_idx = 4'd3;
    expect_evt("R5 same cycle", 1, 2);
    do_reset();
    wr_en = 1; wr_idx = 4'd3;
    @(negedge clk);
    idle();
    ptr_en = 1; ptr_idx = 4'd3;
    expect_evt("R5 next cycle", 0, 0);

    // R6: segment boundaries
    probe_target(16'h00FF, 0);
    probe_target(16'h0100, 1);
    probe_target(16'h03FF, 1);
    probe_target(16'h0400, 0);
    probe_target(16'h7FFF, 0);
    probe_target(16'h8000, 1);
    probe_target(16'h80FF, 1);
    probe_target(16'h8100, 0);
    seg_en = 2'b01;
    probe_target(16'h8010, 0);
    probe_target(16'h0200, 1);
    seg_en = 2'b11;

    // R9: priority
    do_reset();
    fetch_valid = 1; fetch_word = 24'h3F1234;
    ptr_en = 1; ptr_idx = 4'd0;
    reload_en = 1; reload_target = 16'h0100;
    expect_evt("R9 all three", 1, 3);
    do_reset();
    fetch_valid = 1; fetch_word = 24'h3F1234;
    ptr_en = 1; ptr_idx = 4'd1;
    expect_evt("R9 uninit over opcode", 1, 2);

    // R8/R10: held illegal fetch and later events stay silent
    do_reset();
    fetch_valid = 1; fetch_word = 24'h3F0000;
    @(negedge clk);
    chk("R7 first pulse", int'(rst_req), 1);
    chk("R10 cause", int'(cause), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no repeat", int'(rst_req), 0);
    end
    idle();
    ptr_en = 1; ptr_idx = 4'd2;
    @(negedge clk);
    chk("R8 later uninit", int'(rst_req), 0);
    chk("R10 cause held", int'(cause), 1);
    idle();
    do_reset();
    chk("R2 cause cleared", int'(cause), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule